// File: doc/BRIEF.md
# Machine Cycle and Retired-Instruction Counter Bank

This block holds a hart's free-running cycle counter and its retired-instruction counter. It also holds the register that stops either of them from counting and the two registers that decide which lower privilege levels may read the user-visible copies. A CSR unit upstream decodes the instruction, works out the operation and hands this block a single-cycle access. The access carries an address, an enable, a write flag and the final write value. Read data and an illegal-access flag come back combinationally in the same cycle. A write takes effect at the next clock edge.

Each counter is 64 bits wide. With a 32-bit register width, every counter is reached as two halves: the low half sits at the base address and the high half at the base plus 0x80. With a 64-bit register width, the base address reaches all 64 bits and the upper-half addresses do not decode. The machine view is writable. The user view is read-only and also exposes an externally supplied real-time value. Its readability depends on the privilege of the requester and on the two enable registers.

Top module: `hart_counter_bank`

## Requirements
- R1: After reset both counters, the inhibit register and both enable registers are zero.
- R2: The cycle counter (0xB00) increments by one on every clock edge while inhibit bit 0 is clear, and a carry out of the low 32 bits propagates into the high half.
- R3: The retired counter (0xB02) increments by one on each clock edge at which retire_i is high and inhibit bit 2 is clear, and holds otherwise.
- R4: Inhibit register (0x320) bits 0 and 2 are writable and freeze the cycle and retired counters respectively. Bit 1 always reads 0 and has no effect on the time value. A frozen counter holds its value whatever retire_i does.
- R5: A legal write to a counter in the same cycle as its increment loads the written value, and the increment is lost.
- R6: With XLEN=32, 0xB00/0xB02 access bits 31:0 and 0xB80/0xB82 access bits 63:32, and a write to one half leaves the other half unchanged.
- R7: Addresses 0xC00, 0xC01 and 0xC02 (upper halves at 0xC80–0xC82) read the cycle counter, time_i and the retired counter. Any write to them is illegal.
- R8: A read of user-view entry n (0 cycle, 1 time, 2 retired) is illegal below machine level unless bit n of the machine enable register (0x306) is set. From user level (priv 0) it also needs bit n of the supervisor enable register (0x106).
- R9: Address bits 9:8 give the minimum privilege (priv encoding 0 user, 1 supervisor, 3 machine). 0x106 is reachable from supervisor level, and 0xB00/0xB02/0x320/0x306 only from machine level. An access from a lower level is illegal.
- R10: Both enable registers store only bits 2:0 of the write value, and all other bits read 0.
- R11: An access to an unmapped address is illegal (for example 0xB03, 0x305, 0x3A0). Any illegal access returns read data 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | One instruction retired this cycle |
| priv_i | input | 2 | Privilege of the requester (0 U, 1 S, 3 M) |
| time_i | input | 64 | Real-time value exposed through 0xC01/0xC81 |
| csr_en_i | input | 1 | Access valid this cycle |
| csr_we_i | input | 1 | Access writes |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | XLEN | Final write value |
| csr_rdata_o | output | XLEN | Read data, zero when illegal |
| csr_illegal_o | output | 1 | Access is illegal |

## Verification
The bench builds the block with XLEN=32. In this configuration every 64-bit counter is split into halves, so the half-address decode, the preservation of the untouched half on writes and the carry from the low into the high half can all be reached. The counters are frozen through the inhibit register before exact values are written. With that, every expected read value follows from the number of cycles since the last write, including write-over-increment collisions and the single-edge lag of inhibit updates. The 64-bit configuration is covered only by the bound properties.

// File: rtl/hcb_pkg.sv
package hcb_pkg;
  localparam int CNT_W  = 64;
  localparam int N_VIEW = 3;

  localparam logic [11:0] A_MCYC  = 12'hB00;
  localparam logic [11:0] A_MRET  = 12'hB02;
  localparam logic [11:0] A_INHIB = 12'h320;
  localparam logic [11:0] A_MEN   = 12'h306;
  localparam logic [11:0] A_SEN   = 12'h106;
  localparam logic [11:0] A_UCYC  = 12'hC00;
  localparam logic [11:0] A_UTIME = 12'hC01;
  localparam logic [11:0] A_URET  = 12'hC02;
  localparam logic [11:0] A_HI    = 12'h080;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_M = 2'b11;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MCYC,
    SEL_MRET,
    SEL_INHIB,
    SEL_MEN,
    SEL_SEN,
    SEL_VIEW
  } sel_e;

  typedef struct packed {
    sel_e       sel;
    logic       hi;
    logic [1:0] idx;
    logic       illegal;
  } dec_t;
endpackage

// File: rtl/hcb_decode.sv
module hcb_decode
  import hcb_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              en_i,
  input  logic              we_i,
  input  logic [11:0]       addr_i,
  input  logic [1:0]        priv_i,
  input  logic [N_VIEW-1:0] men_i,
  input  logic [N_VIEW-1:0] sen_i,
  output dec_t              dec_o
);
  localparam bit SPLIT = (XLEN < CNT_W);

  logic [11:0] base;
  sel_e        sel;
  logic        ctr_grp;
  logic        priv_ok;
  logic        ro;
  logic        gate_ok;
  logic [3:0]  men_x;
  logic [3:0]  sen_x;

  assign base  = addr_i & ~A_HI;
  assign men_x = 4'(men_i);
  assign sen_x = 4'(sen_i);

  always_comb begin
    sel = SEL_NONE;
    unique case (base)
      A_MCYC:                  sel = SEL_MCYC;
      A_MRET:                  sel = SEL_MRET;
      A_INHIB:                 sel = SEL_INHIB;
      A_MEN:                   sel = SEL_MEN;
      A_SEN:                   sel = SEL_SEN;
      A_UCYC, A_UTIME, A_URET: sel = SEL_VIEW;
      default:                 sel = SEL_NONE;
    endcase
    ctr_grp = (sel == SEL_MCYC) || (sel == SEL_MRET) || (sel == SEL_VIEW);
    // upper-half alias only exists for counters on a split configuration
    if (addr_i[7] && !(ctr_grp && SPLIT)) sel = SEL_NONE;
  end

  assign priv_ok = (priv_i >= addr_i[9:8]);
  assign ro      = (addr_i[11:10] == 2'b11);

  always_comb begin
    gate_ok = 1'b1;
    if (sel == SEL_VIEW && priv_i != PRIV_M) begin
      gate_ok = men_x[addr_i[1:0]];
      if (priv_i == PRIV_U) gate_ok = gate_ok & sen_x[addr_i[1:0]];
    end
  end

  assign dec_o.sel     = sel;
  assign dec_o.hi      = addr_i[7];
  assign dec_o.idx     = addr_i[1:0];
  assign dec_o.illegal = en_i & ((sel == SEL_NONE) | ~priv_ok | (we_i & ro) | ~gate_ok);
endmodule

// File: rtl/hcb_counter.sv
module hcb_counter
  import hcb_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_i,
  input  logic             wr_hi_i,
  input  logic [XLEN-1:0]  wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q;

  if (XLEN < CNT_W) begin : g_split
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
      end else if (wr_i) begin
        if (wr_hi_i) cnt_q[CNT_W-1:HALF] <= wdata_i[HALF-1:0];
        else         cnt_q[HALF-1:0]     <= wdata_i[HALF-1:0];
      end else if (inc_i) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end else begin : g_full
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
      end else if (wr_i) begin
        cnt_q <= wdata_i[CNT_W-1:0];
      end else if (inc_i) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/hcb_rdmux.sv
module hcb_rdmux
  import hcb_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              en_i,
  input  dec_t              dec_i,
  input  logic [CNT_W-1:0]  cyc_i,
  input  logic [CNT_W-1:0]  ret_i,
  input  logic [CNT_W-1:0]  time_i,
  input  logic [N_VIEW-1:0] inh_i,
  input  logic [N_VIEW-1:0] men_i,
  input  logic [N_VIEW-1:0] sen_i,
  output logic [XLEN-1:0]   rdata_o
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] val;
  logic [XLEN-1:0]  sized;

  always_comb begin
    val = '0;
    unique case (dec_i.sel)
      SEL_MCYC:  val = cyc_i;
      SEL_MRET:  val = ret_i;
      SEL_INHIB: val = CNT_W'(inh_i);
      SEL_MEN:   val = CNT_W'(men_i);
      SEL_SEN:   val = CNT_W'(sen_i);
      SEL_VIEW: begin
        unique case (dec_i.idx)
          2'd0:    val = cyc_i;
          2'd1:    val = time_i;
          2'd2:    val = ret_i;
          default: val = '0;
        endcase
      end
      default:   val = '0;
    endcase
  end

  if (XLEN < CNT_W) begin : g_split
    assign sized = dec_i.hi ? val[CNT_W-1:HALF] : val[HALF-1:0];
  end else begin : g_full
    assign sized = val[XLEN-1:0];
  end

  assign rdata_o = (en_i && !dec_i.illegal) ? sized : '0;
endmodule

// File: rtl/hart_counter_bank.sv
module hart_counter_bank
  import hcb_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  input  logic [1:0]       priv_i,
  input  logic [CNT_W-1:0] time_i,
  input  logic             csr_en_i,
  input  logic             csr_we_i,
  input  logic [11:0]      csr_addr_i,
  input  logic [XLEN-1:0]  csr_wdata_i,
  output logic [XLEN-1:0]  csr_rdata_o,
  output logic             csr_illegal_o
);
  localparam int N_CTR = 2;

  dec_t              dec;
  logic              wr_ok;
  logic [N_VIEW-1:0] inh_q;
  logic [N_VIEW-1:0] men_q;
  logic [N_VIEW-1:0] sen_q;
  logic [CNT_W-1:0]  cnt [N_CTR];
  logic [CNT_W-1:0]  cyc_q;
  logic [CNT_W-1:0]  ret_q;
  logic [N_CTR-1:0]  ctr_inc;
  logic [N_CTR-1:0]  ctr_wr;

  hcb_decode #(.XLEN(XLEN)) u_dec (
    .en_i   (csr_en_i),
    .we_i   (csr_we_i),
    .addr_i (csr_addr_i),
    .priv_i (priv_i),
    .men_i  (men_q),
    .sen_i  (sen_q),
    .dec_o  (dec)
  );

  assign wr_ok = csr_en_i & csr_we_i & ~dec.illegal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inh_q <= '0;
      men_q <= '0;
      sen_q <= '0;
    end else if (wr_ok) begin
      unique case (dec.sel)
        SEL_INHIB: inh_q <= {csr_wdata_i[2], 1'b0, csr_wdata_i[0]};
        SEL_MEN:   men_q <= csr_wdata_i[N_VIEW-1:0];
        SEL_SEN:   sen_q <= csr_wdata_i[N_VIEW-1:0];
        default: ;
      endcase
    end
  end

  // counter 0 counts clocks, counter 1 counts retirements
  assign ctr_inc[0] = ~inh_q[0];
  assign ctr_inc[1] = retire_i & ~inh_q[2];
  assign ctr_wr[0]  = wr_ok & (dec.sel == SEL_MCYC);
  assign ctr_wr[1]  = wr_ok & (dec.sel == SEL_MRET);

  for (genvar g = 0; g < N_CTR; g++) begin : g_ctr
    hcb_counter #(.XLEN(XLEN)) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (ctr_inc[g]),
      .wr_i    (ctr_wr[g]),
      .wr_hi_i (dec.hi),
      .wdata_i (csr_wdata_i),
      .cnt_o   (cnt[g])
    );
  end

  assign cyc_q = cnt[0];
  assign ret_q = cnt[1];

  hcb_rdmux #(.XLEN(XLEN)) u_rd (
    .en_i    (csr_en_i),
    .dec_i   (dec),
    .cyc_i   (cyc_q),
    .ret_i   (ret_q),
    .time_i  (time_i),
    .inh_i   (inh_q),
    .men_i   (men_q),
    .sen_i   (sen_q),
    .rdata_o (csr_rdata_o)
  );

  assign csr_illegal_o = dec.illegal;
endmodule

// File: rtl/hcb_checker.sv
module hcb_checker
  import hcb_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              retire_i,
  input logic [1:0]        priv_i,
  input logic [CNT_W-1:0]  time_i,
  input logic              csr_en_i,
  input logic              csr_we_i,
  input logic [11:0]       csr_addr_i,
  input logic [XLEN-1:0]   csr_wdata_i,
  input logic [XLEN-1:0]   csr_rdata_o,
  input logic              csr_illegal_o,
  input logic [CNT_W-1:0]  cyc_q,
  input logic [CNT_W-1:0]  ret_q,
  input logic [N_VIEW-1:0] inh_q,
  input logic [N_VIEW-1:0] men_q,
  input logic [N_VIEW-1:0] sen_q
);
  logic wr_ok;
  logic cyc_wr;
  logic ret_wr;

  assign wr_ok  = csr_en_i & csr_we_i & ~csr_illegal_o;
  assign cyc_wr = wr_ok & ((csr_addr_i == A_MCYC) | (csr_addr_i == (A_MCYC | A_HI)));
  assign ret_wr = wr_ok & ((csr_addr_i == A_MRET) | (csr_addr_i == (A_MRET | A_HI)));

  AST_CYC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inh_q[0] && !cyc_wr) |=> cyc_q == $past(cyc_q) + CNT_W'(1)); // R2

  AST_CYC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh_q[0] && !cyc_wr) |=> $stable(cyc_q)); // R4

  AST_RET_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && !inh_q[2] && !ret_wr) |=> ret_q == $past(ret_q) + CNT_W'(1)); // R3

  AST_RET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!retire_i && !ret_wr) |=> $stable(ret_q)); // R3

  AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && csr_addr_i == A_MCYC) |=> cyc_q[31:0] == $past(csr_wdata_i[31:0])); // R5

  AST_HALF_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((XLEN == 32) && wr_ok && csr_addr_i == A_MRET) |=> ret_q[63:32] == $past(ret_q[63:32])); // R6

  AST_RO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_en_i && csr_we_i && csr_addr_i[11:10] == 2'b11) |-> csr_illegal_o); // R7

  AST_TIME_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_en_i && !csr_illegal_o && csr_addr_i == A_UTIME) |-> csr_rdata_o == time_i[XLEN-1:0]); // R7

  AST_USER_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_en_i && priv_i == PRIV_U && csr_addr_i == A_UCYC && !(men_q[0] && sen_q[0])) |-> csr_illegal_o); // R8

  AST_MPRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_en_i && priv_i != PRIV_M && csr_addr_i[9:8] == 2'b11) |-> csr_illegal_o); // R9

  AST_INH_BIT1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_en_i && !csr_illegal_o && csr_addr_i == A_INHIB) |-> !csr_rdata_o[1]); // R4

  AST_ILL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |-> csr_rdata_o == '0); // R11
endmodule

bind hart_counter_bank hcb_checker #(.XLEN(XLEN)) u_chk (.*);

// File: tb/hart_counter_bank_tb.sv
module hart_counter_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN       = 32;
  localparam int WDOG       = 5000;

  typedef struct {
    logic [31:0] rd;
    logic        ill;
    bit          chk_rd;
    string       tag;
  } exp_t;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             retire_i = 1'b0;
  logic [1:0]       priv_i = 2'd3;
  logic [63:0]      time_i = 64'h0000_0042_DEAD_BEEF;
  logic             csr_en_i = 1'b0;
  logic             csr_we_i = 1'b0;
  logic [11:0]      csr_addr_i = '0;
  logic [XLEN-1:0]  csr_wdata_i = '0;
  logic [XLEN-1:0]  csr_rdata_o;
  logic             csr_illegal_o;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  hart_counter_bank #(.XLEN(XLEN)) u_dut (
    .clk_i, .rst_ni, .retire_i, .priv_i, .time_i,
    .csr_en_i, .csr_we_i, .csr_addr_i, .csr_wdata_i,
    .csr_rdata_o, .csr_illegal_o
  );

  task automatic access(input logic [1:0] pr, input logic [11:0] a, input logic w,
                        input logic [31:0] d, input logic rt, input logic [31:0] e_rd,
                        input logic e_ill, input bit chk, input string tag);
    exp_t e;
    @(posedge clk_i); #1;
    priv_i = pr; csr_addr_i = a; csr_we_i = w; csr_wdata_i = d;
    retire_i = rt; csr_en_i = 1'b1;
    e.rd = e_rd; e.ill = e_ill; e.chk_rd = chk; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic rd(input logic [1:0] pr, input logic [11:0] a, input logic [31:0] e_rd,
                    input logic e_ill, input string tag);
    access(pr, a, 1'b0, '0, 1'b0, e_rd, e_ill, 1'b1, tag);
  endtask

  task automatic rd_rt(input logic [11:0] a, input logic [31:0] e_rd, input string tag);
    access(2'd3, a, 1'b0, '0, 1'b1, e_rd, 1'b0, 1'b1, tag);
  endtask

  task automatic wr(input logic [1:0] pr, input logic [11:0] a, input logic [31:0] d,
                    input logic e_ill, input string tag);
    access(pr, a, 1'b1, d, 1'b0, '0, e_ill, 1'b0, tag);
  endtask

  // monitor: compare each issued access half a cycle later
  initial begin
    forever begin
      @(negedge clk_i);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (csr_illegal_o !== e.ill || (e.chk_rd && csr_rdata_o !== e.rd)) begin
          n_fail++;
          $display("FAIL %s: rdata=%h illegal=%b expected rdata=%h illegal=%b",
                   e.tag, csr_rdata_o, csr_illegal_o, e.rd, e.ill);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < WDOG; i++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    rd(3, 12'h306, 0, 0, "R1 machine enable");
    rd(3, 12'h106, 0, 0, "R1 supervisor enable");
    rd(3, 12'h320, 0, 0, "R1 inhibit");
    rd(3, 12'hB02, 0, 0, "R1 retired low");
    rd(3, 12'hB82, 0, 0, "R1 retired high");
    rd(3, 12'hB80, 0, 0, "R1 cycle high");

    // R4 inhibit bit1 not stored
    wr(3, 12'h320, 32'h7, 0, "R4 inhibit write");
    rd(3, 12'h320, 32'h5, 0, "R4 inhibit readback");

    // R6 halves
    wr(3, 12'hB00, 32'h1234_5678, 0, "R6 write low");
    wr(3, 12'hB80, 32'hA, 0, "R6 write high");
    rd(3, 12'hB00, 32'h1234_5678, 0, "R6 low kept");
    rd(3, 12'hB80, 32'hA, 0, "R6 high");
    wr(3, 12'hB00, 32'h11, 0, "R6 rewrite low");
    rd(3, 12'hB80, 32'hA, 0, "R6 high untouched");
    rd(3, 12'hB00, 32'h11, 0, "R6 low new");

    // R4 frozen retired counter ignores retire
    wr(3, 12'hB02, 32'h5, 0, "R6 retired low");
    wr(3, 12'hB82, 32'h0, 0, "R6 retired high");
    rd_rt(12'hB02, 32'h5, "R4 frozen retired");
    rd(3, 12'hB02, 32'h5, 0, "R4 frozen retired after pulse");

    // R3 retired counting
    wr(3, 12'h320, 32'h1, 0, "R3 unfreeze retired");
    rd_rt(12'hB02, 32'h5, "R3 retire 1");
    rd_rt(12'hB02, 32'h6, "R3 retire 2");
    rd_rt(12'hB02, 32'h7, "R3 retire 3");
    rd(3, 12'hB02, 32'h8, 0, "R3 retired total");

    // R5 write beats increment
    access(3, 12'hB02, 1'b1, 32'd100, 1'b1, '0, 1'b0, 1'b0, "R5 write with retire");
    rd(3, 12'hB02, 32'd100, 0, "R5 write wins");

    // R2 cycle counting and carry
    wr(3, 12'h320, 32'h0, 0, "R2 unfreeze cycle");
    rd(3, 12'hB00, 32'h11, 0, "R2 first");
    rd(3, 12'hB00, 32'h12, 0, "R2 step");
    rd(3, 12'hB00, 32'h13, 0, "R2 step2");
    wr(3, 12'hB00, 32'hFFFF_FFFF, 0, "R5 cycle write");
    rd(3, 12'hB00, 32'hFFFF_FFFF, 0, "R5 cycle write wins");
    rd(3, 12'hB80, 32'hB, 0, "R2 carry into high");
    rd(3, 12'hB00, 32'h1, 0, "R2 low after wrap");
    wr(3, 12'h320, 32'h1, 0, "R4 freeze cycle");

    // R7 user view at machine level
    rd(3, 12'hC00, 32'h3, 0, "R7 cycle view");
    rd(3, 12'hC80, 32'hB, 0, "R7 cycle view high");
    rd(3, 12'hC01, 32'hDEAD_BEEF, 0, "R7 time view");
    rd(3, 12'hC81, 32'h42, 0, "R7 time view high");
    rd(3, 12'hC02, 32'd100, 0, "R7 retired view");
    rd(3, 12'hC82, 32'h0, 0, "R7 retired view high");
    wr(3, 12'h320, 32'h3, 0, "R4 write bit1");
    rd(3, 12'h320, 32'h1, 0, "R4 bit1 reads zero");
    rd(3, 12'hC01, 32'hDEAD_BEEF, 0, "R4 time unaffected");

    // R8 gating
    rd(0, 12'hC00, 0, 1, "R8 user no enables");
    wr(3, 12'h306, 32'h5, 0, "R8 machine enable");
    rd(1, 12'hC00, 32'h3, 0, "R8 supervisor cycle");
    rd(1, 12'hC01, 0, 1, "R8 supervisor time gated");
    rd(1, 12'hC02, 32'd100, 0, "R8 supervisor retired");
    rd(0, 12'hC00, 0, 1, "R8 user needs both");
    wr(3, 12'h106, 32'h1, 0, "R8 supervisor enable");
    rd(0, 12'hC00, 32'h3, 0, "R8 user cycle");
    rd(0, 12'hC02, 0, 1, "R8 user retired gated");

    // R9 privilege
    rd(1, 12'hB00, 0, 1, "R9 supervisor machine counter");
    rd(1, 12'h106, 32'h1, 0, "R9 supervisor own enable");
    rd(0, 12'h106, 0, 1, "R9 user supervisor enable");
    wr(1, 12'h320, 32'h0, 1, "R9 supervisor inhibit write");
    rd(3, 12'h320, 32'h1, 0, "R11 inhibit unchanged");

    // R7 read-only view, R11 no effect
    wr(3, 12'hC00, 32'h0, 1, "R7 view write");
    rd(3, 12'hB00, 32'h3, 0, "R11 cycle unchanged");

    // R11 unmapped
    rd(3, 12'hB03, 0, 1, "R11 unmapped B03");
    rd(3, 12'h305, 0, 1, "R11 unmapped 305");
    rd(3, 12'h3A0, 0, 1, "R11 no high alias");

    // R10 enable width
    wr(3, 12'h306, 32'hFFFF_FFFF, 0, "R10 machine enable all");
    rd(3, 12'h306, 32'h7, 0, "R10 machine enable width");
    wr(3, 12'h106, 32'hFFFF_FFF8, 0, "R10 supervisor enable upper");
    rd(3, 12'h106, 32'h0, 0, "R10 supervisor enable width");

    // R11 illegal write no effect
    wr(1, 12'hB02, 32'h0, 1, "R11 supervisor retired write");
    rd(3, 12'hB02, 32'd100, 0, "R11 retired unchanged");

    @(posedge clk_i); #1;
    csr_en_i = 1'b0; csr_we_i = 1'b0; retire_i = 1'b0;
    while (q.size() > 0) @(posedge clk_i);
    @(posedge clk_i);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule